// File: doc/BRIEF.md
# DMA Channel Scheduler and Physical Address Former

This block sits beside the register file of a four-channel DMA controller. It decides which channel is serviced next and forms the physical memory address for each beat of that channel. It keeps two page bytes per channel, written and read through byte-wide page ports. It also tracks how far each channel has advanced through its block and marks the beat that completes the block. Mode, mask, current address and base count come in from the neighbouring register decode. Requests come from the peripherals as level signals.

A grant names one channel. It stays in place until the memory side acknowledges the beat. On each acknowledge the per-channel offset steps forward, and the arbiter looks again at the pending requests. A parameter selects a word-wide variant, in which every beat moves two bytes and the block length doubles. In the byte variant each beat moves one byte.

Top module: `dma_xfer_sched`

## Requirements
- R1: Page port address bits [2:0] select the channel as follows: 7 selects channel 0, 3 selects channel 1, 1 selects channel 2, and 2 selects channel 3. A write to port 0, 4, 5 or 6 changes no page byte. `pg_hi_sel`=1 selects the high page byte and `pg_hi_sel`=0 selects the low page byte.
- R2: A read from port 0, 4, 5 or 6 returns 0. A read from a valid port returns the last byte written to the selected page byte of that channel. All page bytes are 0 after reset.
- R3: While a grant is held, `phys_addr[30:24]` equals bits [6:0] of the granted channel's high page byte, `phys_addr[23:16]` equals its low page byte, and `phys_addr[15:0]` equals the channel's current address combined with its offset.
- R4: A channel is eligible when its request is pending and its mask bit is 0. When several channels are eligible, the lowest-numbered one is granted. With no grant, `phys_addr`, `mem_req`, `verify_only`, `addr_down`, `autoinit` and `tc_pulse` are all 0.
- R5: A granted channel stays granted, with `grant_chan` unchanged, until the beat is acknowledged. This holds even when a higher-priority request arrives in the meantime.
- R6: The request bit follows `dreq` one clock later. It sets while `dreq` is 1 and clears while `dreq` is 0. An idle arbiter grants on the second rising edge after `dreq` rises.
- R7: Mode bit 5 set gives `addr_down`=1, and the offset is subtracted from the current address modulo 2^16. With bit 5 clear, the offset is added.
- R8: Mode bits [3:2] equal to 00 give `verify_only`=1 and `mem_req`=0 for the granted channel. Any other value gives `mem_req`=1.
- R9: `autoinit` equals mode bit 4 of the granted channel.
- R10: The block length is (base count + 1) bytes, doubled in the word variant. `tc_pulse[c]` is 1 exactly during the acknowledged beat that brings channel c's offset to the block length. After that edge the offset returns to 0.
- R11: Each acknowledged beat advances the granted channel's offset by 1 byte, or by 2 bytes in the word variant. Channels that are not granted keep their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr | input | 1 | Page byte write strobe |
| pg_hi_sel | input | 1 | 1 selects the high page byte, 0 the low one |
| pg_port | input | 3 | Page port address bits [2:0] |
| pg_wdata | input | 8 | Page byte write data |
| pg_rdata | output | 8 | Page byte read data (combinational) |
| dreq | input | 4 | Per-channel request level from peripherals |
| chan_mask | input | 4 | Per-channel mask, 1 blocks the channel |
| chan_mode | input | 32 | Mode byte per channel, channel c at [8c+7:8c] |
| cur_addr | input | 64 | Current 16-bit address per channel |
| base_count | input | 64 | 16-bit base count per channel |
| beat_ack | input | 1 | Memory side completed the current beat |
| grant_valid | output | 1 | A channel is granted |
| grant_chan | output | 2 | Granted channel number |
| phys_addr | output | 31 | Physical byte address of the current beat |
| addr_down | output | 1 | Granted channel walks its address downward |
| verify_only | output | 1 | Granted channel counts without memory access |
| mem_req | output | 1 | A memory access is wanted for this beat |
| autoinit | output | 1 | Granted channel reloads at block end |
| tc_pulse | output | 4 | Terminal-count pulse, one bit per channel |

## Verification
The page read data, `phys_addr`, the flag outputs and `tc_pulse` are combinational from the registered grant and the inputs. The bench therefore checks them 1 ns after it changes an input on a falling edge. A change on `dreq` reaches the request register on the first rising edge and the grant on the second. The bench waits two falling edges before it compares the grant, and it makes one extra one-cycle check that the grant has not yet appeared. A page write, an acknowledged beat, or a grant release takes effect on the single rising edge between the falling edge that drives it and the next one. The expected offsets in the bench model advance at that edge.

// File: rtl/dmasch_pkg.sv
// dmasch_pkg: shared constants, types and decode helpers for the DMA
// channel scheduler. Assumes exactly four channels, as the page port map
// is fixed for four.
package dmasch_pkg;

    localparam int NCH  = 4;
    localparam int CH_W = 2;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        logic addr_down;
        logic autoinit;
        logic verify;
    } mode_bits_t;

    typedef struct packed {
        logic  valid;
        chan_t chan;
    } port_dec_t;

    // Pull the behaviour bits out of a channel mode byte.
    function automatic mode_bits_t decode_mode(input logic [7:0] m);
        mode_bits_t r;
        r.addr_down = m[5];
        r.autoinit  = m[4];
        r.verify    = (m[3:2] == 2'b00);
        return r;
    endfunction

    // Map page port bits [2:0] onto a channel; dead ports return valid=0.
    function automatic port_dec_t page_port_decode(input logic [2:0] p);
        port_dec_t r;
        r.valid = 1'b1;
        r.chan  = '0;
        unique case (p)
            3'd7:    r.chan = 2'd0;
            3'd3:    r.chan = 2'd1;
            3'd1:    r.chan = 2'd2;
            3'd2:    r.chan = 2'd3;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmasch_page_regs.sv
// dmasch_page_regs: low and high page bytes for every channel, reached
// through eight byte ports of which four are dead. Assumes single-byte
// accesses; reads are combinational and have no side effect.
module dmasch_page_regs
    import dmasch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               hi_sel,
    input  logic [2:0]         port,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [NCH*8-1:0]   lo_flat,
    output logic [NCH*8-1:0]   hi_flat
);

    logic [7:0] lo_q [NCH];
    logic [7:0] hi_q [NCH];
    port_dec_t  dec;

    // Port decode shared by the write and read paths.
    assign dec = page_port_decode(port);

    // Store a written byte into the selected page byte of a live port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else if (wr_en && dec.valid) begin
            if (hi_sel) hi_q[dec.chan] <= wdata;
            else        lo_q[dec.chan] <= wdata;
        end
    end

    // Return the selected byte, or zero for a dead port.
    always_comb begin
        rdata = '0;
        if (dec.valid) rdata = hi_sel ? hi_q[dec.chan] : lo_q[dec.chan];
    end

    // Flatten the page bytes for the address former.
    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign lo_flat[g*8 +: 8] = lo_q[g];
        assign hi_flat[g*8 +: 8] = hi_q[g];
    end

endmodule

// File: rtl/dmasch_arbiter.sv
// dmasch_arbiter: fixed-priority grant, lowest channel first. Assumes the
// request vector is already registered; a grant is held until beat_ack.
module dmasch_arbiter
    import dmasch_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] mask,
    input  logic           beat_ack,
    output logic           grant_valid,
    output chan_t          grant_chan
);

    logic [NCH-1:0] elig;
    logic           any_elig;
    chan_t          pick;

    // Eligible channels: request pending and not masked.
    assign elig     = req & ~mask;
    assign any_elig = |elig;

    // Lowest-numbered eligible channel wins.
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) pick = chan_t'(i);
        end
    end

    // Take a new decision only when idle or when the held beat completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_chan  <= '0;
        end else if (!grant_valid || beat_ack) begin
            grant_valid <= any_elig;
            grant_chan  <= pick;
        end
    end

endmodule

// File: rtl/dmasch_beat_counter.sv
// dmasch_beat_counter: byte offset of one channel within its block.
// Assumes base_count is stable while the channel transfers; the offset
// wraps to zero on the beat that reaches the block length.
module dmasch_beat_counter #(
    parameter int ADDR_W = 16,
    parameter int WIDE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_count,
    input  logic              step_en,
    output logic [ADDR_W-1:0] offset,
    output logic              last_beat
);

    localparam int CNT_W = ADDR_W + 1 + WIDE;

    logic [CNT_W-1:0] off_q;
    logic [CNT_W-1:0] blk_len;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] off_next;

    // Block length in bytes and the bytes moved per beat.
    assign blk_len   = (CNT_W'(base_count) + CNT_W'(1)) << WIDE;
    assign step      = CNT_W'(1) << WIDE;
    assign off_next  = off_q + step;
    assign last_beat = (off_next == blk_len);
    assign offset    = off_q[ADDR_W-1:0];

    // Advance on an acknowledged beat of this channel, wrap at block end.
    always_ff @(posedge clk) begin
        if (!rst_n)        off_q <= '0;
        else if (step_en)  off_q <= last_beat ? '0 : off_next;
    end

endmodule

// File: rtl/dma_xfer_sched.sv
// dma_xfer_sched: picks the DMA channel to service, forms the physical
// address of each beat and flags terminal count. Assumes mode, mask,
// current address and base count come from an external register decode
// and are steady while a channel is granted.
module dma_xfer_sched
    import dmasch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIDE   = 0,
    parameter int HI_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pg_wr,
    input  logic                     pg_hi_sel,
    input  logic [2:0]               pg_port,
    input  logic [7:0]               pg_wdata,
    output logic [7:0]               pg_rdata,
    input  logic [3:0]               dreq,
    input  logic [3:0]               chan_mask,
    input  logic [31:0]              chan_mode,
    input  logic [4*ADDR_W-1:0]      cur_addr,
    input  logic [4*ADDR_W-1:0]      base_count,
    input  logic                     beat_ack,
    output logic                     grant_valid,
    output logic [1:0]               grant_chan,
    output logic [HI_W+8+ADDR_W-1:0] phys_addr,
    output logic                     addr_down,
    output logic                     verify_only,
    output logic                     mem_req,
    output logic                     autoinit,
    output logic [3:0]               tc_pulse
);

    localparam int PA_W = HI_W + 8 + ADDR_W;

    logic [NCH-1:0]     req_q;
    logic [NCH*8-1:0]   pg_lo_flat;
    logic [NCH*8-1:0]   pg_hi_flat;
    logic [ADDR_W-1:0]  offs [NCH];
    logic [NCH-1:0]     last_beat;
    logic [NCH-1:0]     step_en;
    mode_bits_t         mode_g;
    logic [ADDR_W-1:0]  cur_g;
    logic [ADDR_W-1:0]  addr_lo;
    logic [7:0]         pg_lo_g;
    logic [7:0]         pg_hi_g;

    // Request bits track the peripheral request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= dreq;
    end

    dmasch_page_regs i_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr),
        .hi_sel  (pg_hi_sel),
        .port    (pg_port),
        .wdata   (pg_wdata),
        .rdata   (pg_rdata),
        .lo_flat (pg_lo_flat),
        .hi_flat (pg_hi_flat)
    );

    dmasch_arbiter i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_q),
        .mask        (chan_mask),
        .beat_ack    (beat_ack),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan)
    );

    // One offset counter per channel, stepped only by its own beats.
    for (genvar g = 0; g < NCH; g++) begin : g_cnt
        assign step_en[g] = beat_ack && grant_valid && (grant_chan == chan_t'(g));

        dmasch_beat_counter #(.ADDR_W(ADDR_W), .WIDE(WIDE)) i_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .base_count (base_count[g*ADDR_W +: ADDR_W]),
            .step_en    (step_en[g]),
            .offset     (offs[g]),
            .last_beat  (last_beat[g])
        );

        // Terminal count coincides with the acknowledge of the final beat.
        assign tc_pulse[g] = step_en[g] && last_beat[g];
    end

    // Select the granted channel's mode, address and page bytes.
    assign mode_g  = decode_mode(chan_mode[grant_chan*8 +: 8]);
    assign cur_g   = cur_addr[grant_chan*ADDR_W +: ADDR_W];
    assign pg_lo_g = pg_lo_flat[grant_chan*8 +: 8];
    assign pg_hi_g = pg_hi_flat[grant_chan*8 +: 8];

    // Walk the low address up or down by the channel's offset.
    assign addr_lo = mode_g.addr_down ? (cur_g - offs[grant_chan])
                                      : (cur_g + offs[grant_chan]);

    // Drive the beat outputs only while a grant is held.
    always_comb begin
        phys_addr   = '0;
        addr_down   = 1'b0;
        verify_only = 1'b0;
        mem_req     = 1'b0;
        autoinit    = 1'b0;
        if (grant_valid) begin
            phys_addr   = PA_W'({pg_hi_g[HI_W-1:0], pg_lo_g, addr_lo});
            addr_down   = mode_g.addr_down;
            verify_only = mode_g.verify;
            mem_req     = !mode_g.verify;
            autoinit    = mode_g.autoinit;
        end
    end

endmodule

// File: rtl/dmasch_checker.sv
// dmasch_checker: temporal properties of the scheduler, bound to the top.
module dmasch_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pg_wr,
    input logic [2:0]  pg_port,
    input logic [31:0] pg_lo_flat,
    input logic [31:0] pg_hi_flat,
    input logic        beat_ack,
    input logic        grant_valid,
    input logic [1:0]  grant_chan,
    input logic        mem_req,
    input logic        verify_only,
    input logic [3:0]  tc_pulse
);

    logic dead_port;
    assign dead_port = (pg_port == 3'd0) || (pg_port == 3'd4)
                    || (pg_port == 3'd5) || (pg_port == 3'd6);

    AST_DEAD_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr && dead_port |=> $stable(pg_lo_flat) && $stable(pg_hi_flat)); // R1

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !beat_ack |=> grant_valid && $stable(grant_chan)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> !mem_req && !verify_only && (tc_pulse == 4'b0)); // R4

    AST_VERIFY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        verify_only |-> !mem_req); // R8

    AST_TC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_pulse)); // R10

    AST_TC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse != 4'b0) |-> beat_ack && grant_valid && tc_pulse[grant_chan]); // R10

endmodule

bind dma_xfer_sched dmasch_checker i_dmasch_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_wr       (pg_wr),
    .pg_port     (pg_port),
    .pg_lo_flat  (pg_lo_flat),
    .pg_hi_flat  (pg_hi_flat),
    .beat_ack    (beat_ack),
    .grant_valid (grant_valid),
    .grant_chan  (grant_chan),
    .mem_req     (mem_req),
    .verify_only (verify_only),
    .tc_pulse    (tc_pulse)
);

// File: tb/test_dma_xfer_sched.sv
`timescale 1ns/1ps
// Bench: sweeps page ports and every mask/request pattern, models offsets.
module test_dma_xfer_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0;
    logic        pg_hi_sel = 1'b0;
    logic [2:0]  pg_port = '0;
    logic [7:0]  pg_wdata = '0;
    logic [7:0]  pg_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  chan_mask = '0;
    logic [31:0] chan_mode;
    logic [63:0] cur_addr;
    logic [63:0] base_count;
    logic        beat_ack = 1'b0;
    logic        grant_valid;
    logic [1:0]  grant_chan;
    logic [30:0] phys_addr;
    logic        addr_down, verify_only, mem_req, autoinit;
    logic [3:0]  tc_pulse;

    int nchk = 0;
    int nerr = 0;

    logic [7:0]  m_mode [4] = '{8'h14, 8'h20, 8'h08, 8'h34};
    logic [15:0] m_base [4] = '{16'd3, 16'd0, 16'd5, 16'd2};
    logic [15:0] m_cur  [4] = '{16'h1000, 16'h0002, 16'hFFFE, 16'h8000};
    logic [7:0]  m_lo   [4];
    logic [7:0]  m_hi   [4];
    int          m_off  [4];

    always #10 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_drv
        assign chan_mode[g*8 +: 8]   = m_mode[g];
        assign cur_addr[g*16 +: 16]  = m_cur[g];
        assign base_count[g*16 +: 16] = m_base[g];
    end

    dma_xfer_sched i_dma_xfer_sched (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_hi_sel(pg_hi_sel),
        .pg_port(pg_port), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
        .dreq(dreq), .chan_mask(chan_mask), .chan_mode(chan_mode),
        .cur_addr(cur_addr), .base_count(base_count), .beat_ack(beat_ack),
        .grant_valid(grant_valid), .grant_chan(grant_chan),
        .phys_addr(phys_addr), .addr_down(addr_down),
        .verify_only(verify_only), .mem_req(mem_req), .autoinit(autoinit),
        .tc_pulse(tc_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int port_chan(input int p);
        case (p)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int lowest(input logic [3:0] e);
        for (int i = 0; i < 4; i++) if (e[i]) return i;
        return 0;
    endfunction

    function automatic logic [30:0] exp_addr(input int c);
        logic [15:0] lo;
        lo = m_mode[c][5] ? (m_cur[c] - 16'(m_off[c])) : (m_cur[c] + 16'(m_off[c]));
        return {m_hi[c][6:0], m_lo[c], lo};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    // Acknowledge the held beat; check the terminal-count pulse (R10, R11).
    task automatic ack_beat();
        int c;
        logic [3:0] exp_tc;
        c = grant_chan;
        exp_tc = (m_off[c] + 1 == int'(m_base[c]) + 1) ? 4'(1 << c) : 4'b0;
        beat_ack = 1'b1;
        #1;
        chk(tc_pulse == exp_tc, "R10 tc pulse", 32'(tc_pulse), 32'(exp_tc));
        tick();
        beat_ack = 1'b0;
        m_off[c] = (m_off[c] + 1 == int'(m_base[c]) + 1) ? 0 : m_off[c] + 1;
    endtask

    task automatic check_grant(input logic [3:0] elig, input string tag);
        int c;
        #1;
        chk(grant_valid == (elig != 0), {tag, " grant_valid"}, 32'(grant_valid), 32'(elig != 0));
        if (elig != 0) begin
            c = lowest(elig);
            chk(grant_chan == 2'(c), {tag, " grant_chan"}, 32'(grant_chan), 32'(c));
            chk(phys_addr == exp_addr(c), "R3 R11 phys_addr", 32'(phys_addr), 32'(exp_addr(c)));
            chk(addr_down == m_mode[c][5], "R7 addr_down", 32'(addr_down), 32'(m_mode[c][5]));
            chk(verify_only == (m_mode[c][3:2] == 2'b00), "R8 verify_only",
                32'(verify_only), 32'(m_mode[c][3:2] == 2'b00));
            chk(mem_req == (m_mode[c][3:2] != 2'b00), "R8 mem_req",
                32'(mem_req), 32'(m_mode[c][3:2] != 2'b00));
            chk(autoinit == m_mode[c][4], "R9 autoinit", 32'(autoinit), 32'(m_mode[c][4]));
        end else begin
            chk(phys_addr == 0 && !mem_req && !verify_only && !addr_down && !autoinit,
                "R4 idle outputs", 32'(phys_addr), 32'h0);
        end
    endtask

    task automatic drain();
        dreq = '0;
        tick(); tick();
        if (grant_valid) ack_beat();
    endtask

    task automatic run_all();
        for (int i = 0; i < 4; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_off[i] = 0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state (R2, R4).
        #1;
        chk(!grant_valid && tc_pulse == 0 && phys_addr == 0, "R4 reset idle",
            32'(grant_valid), 32'h0);
        for (int p = 0; p < 8; p++) begin
            for (int h = 0; h < 2; h++) begin
                pg_port = 3'(p); pg_hi_sel = h[0];
                #1;
                chk(pg_rdata == 8'h00, "R2 reset page read", 32'(pg_rdata), 32'h0);
            end
        end
        // Page port sweep in two passes; dead-port writes must not land (R1, R2).
        for (int pass = 0; pass < 2; pass++) begin
            for (int p = 0; p < 8; p++) begin
                for (int h = 0; h < 2; h++) begin
                    int c;
                    logic [7:0] v;
                    tick();
                    v = 8'((pass * 97) + (p * 16) + (h * 8) + 3);
                    pg_wr = 1'b1; pg_port = 3'(p); pg_hi_sel = h[0]; pg_wdata = v;
                    tick();
                    pg_wr = 1'b0;
                    c = port_chan(p);
                    if (c >= 0) begin
                        if (h == 1) m_hi[c] = v; else m_lo[c] = v;
                    end
                end
            end
            for (int p = 0; p < 8; p++) begin
                for (int h = 0; h < 2; h++) begin
                    int c;
                    logic [7:0] e;
                    pg_port = 3'(p); pg_hi_sel = h[0];
                    #1;
                    c = port_chan(p);
                    e = (c < 0) ? 8'h00 : ((h == 1) ? m_hi[c] : m_lo[c]);
                    chk(pg_rdata == e, (c < 0) ? "R2 dead port read" : "R1 R2 page read",
                        32'(pg_rdata), 32'(e));
                end
            end
        end
        // Request latency (R6).
        tick();
        chan_mask = '0;
        drain();
        dreq = 4'b0100;
        tick(); #1;
        chk(!grant_valid, "R6 no grant after one edge", 32'(grant_valid), 32'h0);
        tick();
        check_grant(4'b0100, "R6");
        // Grant held against a higher-priority arrival (R5).
        drain();
        dreq = 4'b1000;
        tick(); tick();
        check_grant(4'b1000, "R5");
        dreq = 4'b1001;
        repeat (3) tick();
        #1;
        chk(grant_valid && grant_chan == 2'd3, "R5 grant held", 32'(grant_chan), 32'd3);
        ack_beat();
        check_grant(4'b1001, "R4 after release");
        // Every mask and request pattern (R4, R3, R7, R8, R9, R10).
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                drain();
                chan_mask = 4'(m);
                dreq = 4'(r);
                tick(); tick();
                check_grant(4'(r) & ~4'(m), "R4 sweep");
                if (grant_valid) ack_beat();
            end
        end
        // Long run on each channel across two block lengths (R10, R11).
        chan_mask = '0;
        for (int c = 0; c < 4; c++) begin
            drain();
            dreq = 4'(1 << c);
            tick(); tick();
            for (int k = 0; k < 2 * (int'(m_base[c]) + 1); k++) begin
                check_grant(4'(1 << c), "R11 run");
                ack_beat();
            end
        end
        drain();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nerr++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule